// File: doc/BRIEF.md
# Ethernet PHY Transmit Clock Generator

This block builds the transmit-side clocks that an Ethernet MAC wrapper needs for either a reduced gigabit (RGMII) or a reduced (RMII) PHY link. All of its settings come from one packed 32-bit control word. In RGMII mode it picks one of two source clocks, divides that source by a programmable integer, divides the result by a further fixed 2, and passes it through an enable gate. At the intended settings this gives a 125 MHz transmit clock. In RMII mode the transmit chain is silent. Instead the block forwards an internal RMII clock, and it can invert that clock first.

The design lives in one fast clock domain. Each source clock enters as a one-cycle tick strobe at that source's rate. The block counts the ticks of the selected source. The transmit clock output is a level that holds each half period for N ticks of the selected source, where N is the effective divisor. The divisor and the source choice are taken in only at a divider boundary. The gate opens and closes only while the transmit clock is low. Together these two rules mean the output never carries a shortened pulse.

The divider runs the state machine `DIV_IDLE`/`DIV_COUNT`. `DIV_IDLE` goes to `DIV_COUNT` when the generator runs, and goes back when it stops. The gate runs `GATE_OFF`/`GATE_RUN`/`GATE_DRAIN` with these transitions:
- `GATE_OFF` goes to `GATE_RUN` on a gate request while the clock is low.
- `GATE_RUN` goes to `GATE_OFF` when the request drops while the clock is low.
- `GATE_RUN` goes to `GATE_DRAIN` when the request drops while the clock is high.
- `GATE_DRAIN` goes to `GATE_RUN` if the request returns.
- `GATE_DRAIN` goes to `GATE_OFF` once the clock is low.
- Every gate state goes to `GATE_OFF` when the generator stops.

Top module: `ethclk_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `tx_clk_o` and `rmii_clk_o` are 0.
- R2: Control bit 0 picks the mode. 1 selects RGMII, where the transmit clock may run. 0 selects RMII, where `tx_clk_o` stays 0.
- R3: Control bit 4 picks the divider source. 0 counts `src_tick_i[0]` and 1 counts `src_tick_i[1]`.
- R4: For a divisor field (bits 9:7) value N from 2 to 7, each high phase and each low phase of `tx_clk_o` lasts N ticks of the selected source.
- R5: Divisor field values 0 and 1 divide by 1. Each half period then lasts one source tick, so the output never stalls.
- R6: A fixed divide-by-2 follows the divider, so a full `tx_clk_o` period is 2N source ticks with equal high and low phases.
- R7: Control bit 10 gates `tx_clk_o`. The gate opens or closes only while the clock is low. A high phase in progress when the gate is cleared completes at full length, and after that the output stays 0.
- R8: In RMII mode, with the generator enabled, `rmii_clk_o` equals `rmii_clk_i` XOR control bit 11, one cycle later. In RGMII mode `rmii_clk_o` is 0 and bit 11 has no effect.
- R9: Control bit 12 enables the generator. When it is 0, both outputs are 0 from the next cycle on. When it is set again, the transmit clock resumes.
- R10: A new divisor or source setting takes effect only at the end of the current divider interval. The half period in progress keeps the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Packed control word |
| src_tick_i | input | 2 | One-cycle strobes marking each edge of the two source clocks |
| rmii_clk_i | input | 1 | Internal RMII clock level |
| tx_clk_o | output | 1 | Gated, divided transmit clock level |
| rmii_clk_o | output | 1 | Forwarded, optionally inverted RMII clock |

## Verification
The bench measures every high and low run of the transmit clock for the divisors 2, 3 and 7, for the bypass codes 0 and 1, and for the slower second source. A wrong divide chain shows up as a run of the wrong length. Clearing the gate in the middle of a high phase must leave a full-length pulse, so a gate that cuts the clock at once fails this check with a runt. The divisor is changed from 3 to 5 partway through a half period; a divider that compares against the live field stretches that half period to 5. The bench also drives the inversion bit in both modes and clears the generator enable, so a leak of the inversion into RGMII mode or a missing enable shows up on the outputs.

// File: rtl/ethclk_pkg.sv
package ethclk_pkg;

    // Control word layout; the divider field and bit roles are decoded by the block.
    localparam int CFG_W     = 32;
    localparam int B_MODE    = 0;
    localparam int B_SRC     = 4;
    localparam int DIV_LSB   = 7;
    localparam int DIV_W     = 3;
    localparam int B_GATE    = 10;
    localparam int B_INV     = 11;
    localparam int B_GEN     = 12;
    localparam int N_SRC     = 2;
    localparam int SEL_W     = $clog2(N_SRC);

    typedef struct packed {
        logic             rgmii;
        logic [SEL_W-1:0] src_sel;
        logic [DIV_W-1:0] div_eff;
        logic             tx_run;
        logic             rmii_run;
        logic             gate_req;
        logic             inv_eff;
    } ctl_t;

    typedef enum logic {
        DIV_IDLE,
        DIV_COUNT
    } div_state_e;

    typedef enum logic [1:0] {
        GATE_OFF,
        GATE_RUN,
        GATE_DRAIN
    } gate_state_e;

endpackage

// File: rtl/ethclk_cfg_decode.sv
module ethclk_cfg_decode
    import ethclk_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_i,
    output ctl_t             ctl_o
);

    logic [DIV_W-1:0] div_fld;
    logic             gen_en;
    logic             unused_cfg;

    assign div_fld = cfg_i[DIV_LSB +: DIV_W];
    assign gen_en  = cfg_i[B_GEN];

    // Bits not used by this block are kept visible and discarded here.
    assign unused_cfg = ^{cfg_i[CFG_W-1:B_GEN+1], cfg_i[DIV_LSB-1:B_SRC+1],
                          cfg_i[B_SRC-1:B_MODE+1]};

    always_comb begin
        ctl_o          = '0;
        ctl_o.rgmii    = cfg_i[B_MODE];
        ctl_o.src_sel  = SEL_W'(cfg_i[B_SRC]);
        // Codes below 2 are illegal divisors; treat them as pass-through.
        ctl_o.div_eff  = (div_fld < DIV_W'(2)) ? DIV_W'(1) : div_fld;
        ctl_o.tx_run   = gen_en & cfg_i[B_MODE];
        ctl_o.rmii_run = gen_en & ~cfg_i[B_MODE];
        ctl_o.gate_req = cfg_i[B_GATE] & gen_en & cfg_i[B_MODE];
        // Inversion only matters for the RMII path.
        ctl_o.inv_eff  = cfg_i[B_INV] & ~cfg_i[B_MODE];
    end

endmodule

// File: rtl/ethclk_divider.sv
module ethclk_divider
    import ethclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [N_SRC-1:0] src_tick_i,
    output logic             div_tick_o
);

    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;
    logic [SEL_W-1:0] sel_q;
    logic             sel_tick;
    logic             wrap;
    logic             tick_q;

    assign sel_tick = src_tick_i[sel_q];
    assign wrap     = (state_q == DIV_COUNT) && sel_tick && (cnt_q == lim_q - DIV_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE:  if (run_i)  state_d = DIV_COUNT;
            DIV_COUNT: if (!run_i) state_d = DIV_IDLE;
            default:   state_d = DIV_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    // Counter, shadowed settings and tick output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= DIV_W'(1);
            sel_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap && run_i;
            if (state_q == DIV_IDLE || wrap) begin
                // New divisor and source are taken only here.
                cnt_q <= '0;
                lim_q <= div_i;
                sel_q <= sel_i;
            end else if (sel_tick) begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end

    assign div_tick_o = tick_q;

endmodule

// File: rtl/ethclk_gate.sv
module ethclk_gate
    import ethclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic div_tick_i,
    input  logic gate_i,
    output logic tx_clk_o
);

    gate_state_e state_q, state_d;
    logic        phase_q;

    // Fixed divide-by-2 stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          phase_q <= 1'b0;
        else if (!run_i)     phase_q <= 1'b0;
        else if (div_tick_i) phase_q <= ~phase_q;
    end

    // Next-state logic: the gate changes only while the clock is low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: begin
                if (gate_i && !phase_q) state_d = GATE_RUN;
            end
            GATE_RUN: begin
                if (!gate_i) state_d = phase_q ? GATE_DRAIN : GATE_OFF;
            end
            GATE_DRAIN: begin
                if (gate_i)        state_d = GATE_RUN;
                else if (!phase_q) state_d = GATE_OFF;
            end
            default: state_d = GATE_OFF;
        endcase
        if (!run_i) state_d = GATE_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    // Output
    always_comb begin
        tx_clk_o = phase_q && (state_q != GATE_OFF);
    end

endmodule

// File: rtl/ethclk_rmii.sv
module ethclk_rmii (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic inv_i,
    input  logic rmii_clk_i,
    output logic rmii_clk_o
);

    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= run_i & (rmii_clk_i ^ inv_i);
    end

    assign rmii_clk_o = out_q;

endmodule

// File: rtl/ethclk_gen.sv
module ethclk_gen
    import ethclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [N_SRC-1:0] src_tick_i,
    input  logic             rmii_clk_i,
    output logic             tx_clk_o,
    output logic             rmii_clk_o
);

    ctl_t ctl;
    logic div_tick;

    ethclk_cfg_decode u_decode (
        .cfg_i (cfg_i),
        .ctl_o (ctl)
    );

    ethclk_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctl.tx_run),
        .sel_i      (ctl.src_sel),
        .div_i      (ctl.div_eff),
        .src_tick_i (src_tick_i),
        .div_tick_o (div_tick)
    );

    ethclk_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctl.tx_run),
        .div_tick_i (div_tick),
        .gate_i     (ctl.gate_req),
        .tx_clk_o   (tx_clk_o)
    );

    ethclk_rmii u_rmii (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctl.rmii_run),
        .inv_i      (ctl.inv_eff),
        .rmii_clk_i (rmii_clk_i),
        .rmii_clk_o (rmii_clk_o)
    );

endmodule

// File: rtl/ethclk_gen_chk.sv
module ethclk_gen_chk
    import ethclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_i,
    input logic             rmii_clk_i,
    input logic             tx_clk_o,
    input logic             rmii_clk_o
);

    assert_gate_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i[B_GATE] && !tx_clk_o) |=> !tx_clk_o);

    assert_rmii_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i[B_MODE] && !tx_clk_o) |=> !tx_clk_o);

    assert_gen_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[B_GEN] |=> (!tx_clk_o && !rmii_clk_o));

    assert_rgmii_no_rmii_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[B_MODE] |=> !rmii_clk_o);

    assert_rmii_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[B_GEN] && !cfg_i[B_MODE]) |=>
            (rmii_clk_o == ($past(rmii_clk_i) ^ $past(cfg_i[B_INV]))));

endmodule

bind ethclk_gen ethclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_i),
    .rmii_clk_i (rmii_clk_i),
    .tx_clk_o   (tx_clk_o),
    .rmii_clk_o (rmii_clk_o)
);

// File: tb/test_ethclk_gen.sv
module test_ethclk_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = '0;
    logic [1:0]  src_tick = 2'b01;
    logic        rmii_in = 1'b0;
    logic        tx_clk_o;
    logic        rmii_clk_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    mon_arm = 1'b0;

    ethclk_gen i_ethclk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .src_tick_i (src_tick),
        .rmii_clk_i (rmii_in),
        .tx_clk_o   (tx_clk_o),
        .rmii_clk_o (rmii_clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(bit rg, bit src, int dv, bit gt, bit inv, bit gen);
        logic [31:0] w;
        w = '0;
        w[0]   = rg;
        w[4]   = src;
        w[9:7] = 3'(dv);
        w[10]  = gt;
        w[11]  = inv;
        w[12]  = gen;
        return w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Second source ticks every third cycle
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == 2) ? 0 : ph + 1;
            src_tick[1] = (ph == 0);
        end
    end

    // Monitor: measures run lengths of tx_clk_o and compares them with the scoreboard
    initial begin
        bit   have_start = 1'b0;
        int   run = 0;
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!mon_arm) begin
                have_start = 1'b0;
            end else if (tx_clk_o !== prev) begin
                if (have_start && exp_q.size() > 0) begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(run == e, t, run, e);
                end
                have_start = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            prev = tx_clk_o;
        end
    end

    task automatic push_runs(int n, int len, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(len);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_q(int sz);
        while (exp_q.size() != sz) @(negedge clk);
    endtask

    task automatic run_runs(int n, int len, string tag);
        push_runs(n, len, tag);
        mon_arm = 1'b1;
        wait_q(0);
        @(negedge clk);
        mon_arm = 1'b0;
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hold_low(int n, string tag);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_clk_o !== 1'b0) highs++;
        end
        chk(highs == 0, tag, highs, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        // R1: reset state
        settle(3);
        chk(tx_clk_o === 1'b0, "R1 tx", int'(tx_clk_o), 0);
        chk(rmii_clk_o === 1'b0, "R1 rmii", int'(rmii_clk_o), 0);
        cfg = mk(1, 0, 2, 1, 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_clk_o === 1'b0, "R1 after release", int'(tx_clk_o), 0);

        // R4 / R6: programmable divisor on first source
        settle(10);
        run_runs(4, 2, "R4 div2");
        cfg = mk(1, 0, 3, 1, 0, 1); settle(20);
        run_runs(4, 3, "R4 div3");
        cfg = mk(1, 0, 7, 1, 0, 1); settle(30);
        run_runs(4, 7, "R6 div7");

        // R5: bypass codes
        cfg = mk(1, 0, 0, 1, 0, 1); settle(30);
        run_runs(4, 1, "R5 code0");
        cfg = mk(1, 0, 1, 1, 0, 1); settle(10);
        run_runs(4, 1, "R5 code1");

        // R3: second source, ticks every 3 cycles
        cfg = mk(1, 1, 2, 1, 0, 1); settle(30);
        run_runs(4, 6, "R3 src1");

        // R10: divisor change mid half-period
        cfg = mk(1, 0, 3, 1, 0, 1); settle(30);
        push_runs(2, 3, "R10 old");
        push_runs(2, 5, "R10 new");
        mon_arm = 1'b1;
        wait_q(3);
        @(negedge clk);
        cfg = mk(1, 0, 5, 1, 0, 1);
        wait_q(0);
        @(negedge clk);
        mon_arm = 1'b0;

        // R7: clear gate during a high phase
        cfg = mk(1, 0, 7, 1, 0, 1); settle(30);
        do @(negedge clk); while (tx_clk_o !== 1'b0);
        do @(negedge clk); while (tx_clk_o !== 1'b1);
        hi = 1;
        while (1) begin
            @(negedge clk);
            if (tx_clk_o !== 1'b1) break;
            hi++;
            if (hi == 3) cfg = mk(1, 0, 7, 0, 0, 1);
        end
        chk(hi == 7, "R7 full pulse", hi, 7);
        hold_low(40, "R7 gated low");
        cfg = mk(1, 0, 7, 1, 0, 1);
        run_runs(3, 7, "R7 reopen");

        // R2: RMII mode keeps tx quiet
        cfg = mk(0, 0, 2, 1, 0, 1);
        settle(2);
        hold_low(40, "R2 rmii tx");

        // R8: RMII inversion
        rmii_in = 1'b0; cfg = mk(0, 0, 2, 0, 1, 1); settle(2);
        chk(rmii_clk_o === 1'b1, "R8 inv of 0", int'(rmii_clk_o), 1);
        rmii_in = 1'b1; settle(2);
        chk(rmii_clk_o === 1'b0, "R8 inv of 1", int'(rmii_clk_o), 0);
        cfg = mk(0, 0, 2, 0, 0, 1); settle(2);
        chk(rmii_clk_o === 1'b1, "R8 pass 1", int'(rmii_clk_o), 1);
        rmii_in = 1'b0; cfg = mk(1, 0, 2, 0, 1, 1); settle(2);
        chk(rmii_clk_o === 1'b0, "R8 rgmii ignores inv", int'(rmii_clk_o), 0);

        // R9: generator enable
        cfg = mk(1, 0, 2, 1, 0, 0);
        settle(2);
        hold_low(40, "R9 gen off tx");
        rmii_in = 1'b1; cfg = mk(0, 0, 2, 0, 0, 0); settle(2);
        chk(rmii_clk_o === 1'b0, "R9 gen off rmii", int'(rmii_clk_o), 0);
        cfg = mk(1, 0, 2, 1, 0, 1); settle(10);
        run_runs(3, 2, "R9 resume");

        finish_run();
    end

endmodule